// File: doc/BRIEF.md
# Clock Divider Setting Search Engine

This block picks a two-stage clock divider setting. It takes a module clock frequency and a target frequency and walks a small set of prescaler values against a set of scaler values. For each pair it computes the truncated frequency `module_clock / (prescaler * scaler)`. It returns the indices of the pair whose frequency comes closest to the target from below, together with that frequency. An error flag is raised when no pair reaches the target.

Two divisor tables are available and `mode_i` selects one of them. Baud mode uses an irregular scaler ladder whose early steps are not all powers of two. Delay mode uses odd prescalers and pure power-of-two scalers.

The search is driven by a start pulse. The block reports busy while it runs and gives a one-cycle done pulse when it finishes. All quotients come from one shared restoring divider that produces one bit per cycle.

Top module: `clkdiv_search`

## Requirements
- R1: With `mode_i`=0 (baud), prescaler index 0..3 selects 2, 3, 5, 7, and scaler index 0..15 selects 2, 4, 6, 8, 16, 32, ... 32768 (index k>=3 is 2^k).
- R2: With `mode_i`=1 (delay), prescaler index i selects 2*i+1, and scaler index k selects 2^(k+1), so the scalers run from 2 to 65536.
- R3: Each candidate frequency is floor(`mod_clk_i` / (prescaler * scaler)), computed with unsigned 32-bit integer division.
- R4: For each prescaler, scalers are tried in ascending index order. Only the first candidate that is less than or equal to `target_i` is considered for that prescaler.
- R5: A considered candidate replaces the stored result only when it is strictly greater than it. On a tie the lower prescaler index is kept.
- R6: When no pair yields a frequency at or below the target, `err_o` is 1 and `freq_o` is 0 at done.
- R7: A `mod_clk_i` of 0 ends the search with `err_o`=1, `freq_o`=0 and both index outputs 0.
- R8: `done_o` is high for exactly one cycle with `busy_o` low. All result outputs hold their value until the next done.
- R9: A `start_i` seen while `busy_o` is high is ignored: the running search completes with the inputs captured at its own start.
- R10: On a successful search, `freq_o` never exceeds the target captured at start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Starts a search when idle; captures the mode, clock and target inputs |
| mode_i | input | 1 | Table select: 0 baud, 1 delay |
| mod_clk_i | input | 32 | Module clock frequency in Hz |
| target_i | input | 32 | Highest allowed output frequency in Hz |
| busy_o | output | 1 | A search is in progress |
| done_o | output | 1 | One-cycle pulse when a result is posted |
| err_o | output | 1 | No valid setting was found, or the module clock was 0 |
| pre_idx_o | output | 2 | Index of the chosen prescaler |
| scl_idx_o | output | 4 | Index of the chosen scaler |
| freq_o | output | 32 | Frequency achieved by the chosen pair, 0 on error |

## Verification
The assertions assume that `start_i` stays low at reset and that the divisor read from the table is never zero. Both table formulas give at least 2, which guarantees the second assumption. The quotient check also assumes the selected table indices do not change while a division runs. The bench keeps to these assumptions: it raises `start_i` only for single cycles after reset, and it drives the mode, clock and target inputs on the falling edge. Some of those values are changed mid-search on purpose, so the bench can show that the captured copies, and not the live inputs, steer the search.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ISSUE,
    ST_WAIT,
    ST_FINISH
  } srch_state_e;

  localparam logic MODE_BAUD  = 1'b0;
  localparam logic MODE_DELAY = 1'b1;

  // prescaler value for a table index
  function automatic logic [31:0] pre_val(input logic mode, input logic [31:0] idx);
    if (mode == MODE_BAUD && idx == 32'd0) return 32'd2;
    return 32'd2 * idx + 32'd1;
  endfunction

  // scaler value for a table index; baud ladder starts 2,4,6,8
  function automatic logic [31:0] scl_val(input logic mode, input logic [31:0] idx);
    if (mode == MODE_DELAY) return 32'd1 << (idx + 32'd1);
    if (idx < 32'd3) return 32'd2 * idx + 32'd2;
    return 32'd1 << idx;
  endfunction

endpackage

// File: rtl/clkdiv_table.sv
module clkdiv_table
  import clkdiv_pkg::*;
#(
  parameter int W     = 32,
  parameter int PRE_W = 2,
  parameter int SCL_W = 4
) (
  input  logic             mode_i,
  input  logic [PRE_W-1:0] pre_idx_i,
  input  logic [SCL_W-1:0] scl_idx_i,
  output logic [W-1:0]     divisor_o
);

  logic [31:0] pre_v;
  logic [31:0] scl_v;
  logic [63:0] prod;

  always_comb begin
    pre_v     = pre_val(mode_i, 32'(pre_idx_i));
    scl_v     = scl_val(mode_i, 32'(scl_idx_i));
    prod      = 64'(pre_v) * 64'(scl_v);
    divisor_o = W'(prod);
  end

endmodule

// File: rtl/clkdiv_divider.sv
module clkdiv_divider #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic [W-1:0] dividend_i,
  input  logic [W-1:0] divisor_i,
  output logic         busy_o,
  output logic         done_o,
  output logic [W-1:0] quot_o
);

  localparam int CNT_W = $clog2(W + 1);

  logic [W-1:0]     rem_q;
  logic [W-1:0]     quo_q;
  logic [CNT_W-1:0] cnt_q;
  logic [W:0]       shifted;
  logic [W:0]       diff;
  logic             ge;

  always_comb begin
    shifted = {rem_q, quo_q[W-1]};
    ge      = shifted >= {1'b0, divisor_i};
    diff    = shifted - {1'b0, divisor_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q  <= '0;
      quo_q  <= '0;
      cnt_q  <= '0;
      busy_o <= 1'b0;
      done_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (start_i && !busy_o) begin
        rem_q  <= '0;
        quo_q  <= dividend_i;
        cnt_q  <= CNT_W'(W);
        busy_o <= 1'b1;
      end else if (busy_o) begin
        rem_q <= ge ? diff[W-1:0] : shifted[W-1:0];
        quo_q <= {quo_q[W-2:0], ge};
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == CNT_W'(1)) begin
          busy_o <= 1'b0;
          done_o <= 1'b1;
        end
      end
    end
  end

  assign quot_o = quo_q;

  a_r3_done_after_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> $past(busy_o));

endmodule

// File: rtl/clkdiv_search.sv
module clkdiv_search
  import clkdiv_pkg::*;
#(
  parameter int W       = 32,
  parameter int NUM_PRE = 4,
  parameter int NUM_SCL = 16
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       start_i,
  input  logic                       mode_i,
  input  logic [W-1:0]               mod_clk_i,
  input  logic [W-1:0]               target_i,
  output logic                       busy_o,
  output logic                       done_o,
  output logic                       err_o,
  output logic [$clog2(NUM_PRE)-1:0] pre_idx_o,
  output logic [$clog2(NUM_SCL)-1:0] scl_idx_o,
  output logic [W-1:0]               freq_o
);

  localparam int PRE_W = $clog2(NUM_PRE);
  localparam int SCL_W = $clog2(NUM_SCL);
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(NUM_PRE - 1);
  localparam logic [SCL_W-1:0] SCL_LAST = SCL_W'(NUM_SCL - 1);

  srch_state_e      state_q;
  logic             mode_q;
  logic [W-1:0]     clk_q, tgt_q;
  logic [PRE_W-1:0] pi_q, best_pi_q;
  logic [SCL_W-1:0] si_q, best_si_q;
  logic [W-1:0]     best_q;
  logic             found_q;

  logic [W-1:0] divisor;
  logic         div_busy, div_done;
  logic [W-1:0] div_q;
  logic         fits, better;

  clkdiv_table #(.W(W), .PRE_W(PRE_W), .SCL_W(SCL_W)) table_i (
    .mode_i    (mode_q),
    .pre_idx_i (pi_q),
    .scl_idx_i (si_q),
    .divisor_o (divisor)
  );

  clkdiv_divider #(.W(W)) div_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (state_q == ST_ISSUE),
    .dividend_i (clk_q),
    .divisor_i  (divisor),
    .busy_o     (div_busy),
    .done_o     (div_done),
    .quot_o     (div_q)
  );

  assign fits   = div_q <= tgt_q;
  assign better = !found_q || (div_q > best_q);
  assign busy_o = (state_q != ST_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      mode_q    <= MODE_BAUD;
      clk_q     <= '0;
      tgt_q     <= '0;
      pi_q      <= '0;
      si_q      <= '0;
      best_q    <= '0;
      best_pi_q <= '0;
      best_si_q <= '0;
      found_q   <= 1'b0;
      done_o    <= 1'b0;
      err_o     <= 1'b0;
      pre_idx_o <= '0;
      scl_idx_o <= '0;
      freq_o    <= '0;
    end else begin
      done_o <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          mode_q    <= mode_i;
          clk_q     <= mod_clk_i;
          tgt_q     <= target_i;
          pi_q      <= '0;
          si_q      <= '0;
          best_q    <= '0;
          best_pi_q <= '0;
          best_si_q <= '0;
          found_q   <= 1'b0;
          state_q   <= (mod_clk_i == '0) ? ST_FINISH : ST_ISSUE;
        end
        ST_ISSUE: state_q <= ST_WAIT;
        ST_WAIT: if (div_done) begin
          // first fitting scaler closes this prescaler's scan
          if (fits || si_q == SCL_LAST) begin
            if (fits && better) begin
              best_q    <= div_q;
              best_pi_q <= pi_q;
              best_si_q <= si_q;
              found_q   <= 1'b1;
            end
            si_q <= '0;
            if (pi_q == PRE_LAST) begin
              state_q <= ST_FINISH;
            end else begin
              pi_q    <= pi_q + 1'b1;
              state_q <= ST_ISSUE;
            end
          end else begin
            si_q    <= si_q + 1'b1;
            state_q <= ST_ISSUE;
          end
        end
        ST_FINISH: begin
          done_o    <= 1'b1;
          err_o     <= !found_q;
          freq_o    <= found_q ? best_q : '0;
          pre_idx_o <= found_q ? best_pi_q : '0;
          scl_idx_o <= found_q ? best_si_q : '0;
          state_q   <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R3: quotient from the shared divider is the truncated ratio
  a_r3_trunc_quotient: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (div_done && state_q == ST_WAIT) |->
      ((64'(div_q) * 64'(divisor) <= 64'(clk_q)) &&
       (64'(clk_q) - 64'(div_q) * 64'(divisor) < 64'(divisor))));

  a_r8_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r8_done_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  a_r8_hold_result: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |=> ($stable(freq_o) && $stable(err_o) && $stable(pre_idx_o) && $stable(scl_idx_o)));

  a_r6_err_zero_freq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && err_o) |-> (freq_o == '0));

  a_r10_not_above: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !err_o) |-> (freq_o <= tgt_q));

  a_r9_capture_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> ($stable(tgt_q) && $stable(clk_q) && $stable(mode_q)));

endmodule

// File: tb/clkdiv_search_tb_top.sv
module clkdiv_search_tb_top;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic        mode_i = 1'b0;
  logic [31:0] mod_clk_i = '0;
  logic [31:0] target_i = '0;
  logic        busy_o, done_o, err_o;
  logic [1:0]  pre_idx_o;
  logic [3:0]  scl_idx_o;
  logic [31:0] freq_o;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  always #2 clk_i = ~clk_i;

  clkdiv_search dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .mode_i(mode_i),
    .mod_clk_i(mod_clk_i), .target_i(target_i), .busy_o(busy_o), .done_o(done_o),
    .err_o(err_o), .pre_idx_o(pre_idx_o), .scl_idx_o(scl_idx_o), .freq_o(freq_o)
  );

  always @(posedge clk_i) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      fails  = fails + 1;
      checks = checks + 1;
      $display("FAIL watchdog: actual %0d cycles expected < 150000", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // independent tables built from R1/R2
  function automatic longint ref_pre(input bit mode, input int i);
    longint baud[4] = '{2, 3, 5, 7};
    return mode ? longint'(2 * i + 1) : baud[i];
  endfunction

  function automatic longint ref_scl(input bit mode, input int k);
    longint baud[16] = '{2, 4, 6, 8, 16, 32, 64, 128, 256, 512, 1024, 2048,
                         4096, 8192, 16384, 32768};
    return mode ? (longint'(1) << (k + 1)) : baud[k];
  endfunction

  task automatic ref_search(input bit mode, input longint mclk, input longint tgt,
                            output int ep, output int es, output longint ef, output bit ee);
    longint best = -1;
    ep = 0; es = 0; ef = 0; ee = 1;
    if (mclk == 0) return;
    for (int i = 0; i < 4; i++) begin
      for (int k = 0; k < 16; k++) begin
        longint f = mclk / (ref_pre(mode, i) * ref_scl(mode, k));
        if (f <= tgt) begin
          if (f > best) begin best = f; ep = i; es = k; end
          break;
        end
      end
    end
    if (best >= 0) begin ef = best; ee = 0; end
  endtask

  task automatic pulse_start(input bit mode, input logic [31:0] mclk, input logic [31:0] tgt);
    @(negedge clk_i);
    mode_i = mode; mod_clk_i = mclk; target_i = tgt; start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
  endtask

  task automatic wait_done();
    while (!done_o) @(negedge clk_i);
  endtask

  task automatic check_result(input string req, input bit mode, input logic [31:0] mclk,
                              input logic [31:0] tgt);
    int ep, es; longint ef; bit ee;
    ref_search(mode, mclk, tgt, ep, es, ef, ee);
    chk(err_o == ee, {req, " err"}, err_o, ee);
    chk(freq_o == ef, {req, " freq"}, freq_o, ef);
    chk(pre_idx_o == ep, {req, " pre_idx"}, pre_idx_o, ep);
    chk(scl_idx_o == es, {req, " scl_idx"}, scl_idx_o, es);
  endtask

  task automatic run_case(input string req, input bit mode, input logic [31:0] mclk,
                          input logic [31:0] tgt);
    pulse_start(mode, mclk, tgt);
    wait_done();
    check_result(req, mode, mclk, tgt);
    chk(!busy_o, "R8 busy low at done", busy_o, 0);
  endtask

  task automatic test_reset();
    chk(!busy_o && !done_o, "R8 reset idle", {busy_o, done_o}, 0);
    chk(!err_o && freq_o == 0, "R8 reset outputs", freq_o, 0);
  endtask

  task automatic test_baud_sweep();
    logic [31:0] tg[5] = '{100000, 400000, 1000000, 5000000, 10000000};
    foreach (tg[n]) run_case("R1 R4 baud", 1'b0, 32'd48000000, tg[n]);
    foreach (tg[n]) run_case("R3 baud 120M", 1'b0, 32'd120000000, tg[n]);
  endtask

  task automatic test_delay_sweep();
    logic [31:0] tg[5] = '{100000, 400000, 1000000, 5000000, 10000000};
    foreach (tg[n]) run_case("R2 delay", 1'b1, 32'd48000000, tg[n]);
  endtask

  task automatic test_known();
    // R4: clk 60 target 10 -> prescaler 3 (idx1) scaler 2 (idx0), 10 Hz
    run_case("R4 known", 1'b0, 32'd60, 32'd10);
    chk(freq_o == 10 && pre_idx_o == 1 && scl_idx_o == 0, "R4 hand value", freq_o, 10);
    // R5: 120/(2*6)=10 ties 120/(3*4)=10; lower prescaler wins, scaler idx 2 (value 6)
    run_case("R5 tie", 1'b0, 32'd120, 32'd10);
    chk(pre_idx_o == 0 && scl_idx_o == 2, "R5 tie keeps lower prescaler",
        {pre_idx_o, scl_idx_o}, 2);
  endtask

  task automatic test_error();
    run_case("R6 baud none", 1'b0, 32'hFFFFFFFF, 32'd1000);
    chk(err_o && freq_o == 0, "R6 baud err", freq_o, 0);
    run_case("R6 delay none", 1'b1, 32'hFFFFFFFF, 32'd1000);
    chk(err_o && freq_o == 0, "R6 delay err", freq_o, 0);
  endtask

  task automatic test_zero_clk();
    run_case("R7 zero clk", 1'b0, 32'd0, 32'd1000);
    chk(err_o && freq_o == 0 && pre_idx_o == 0 && scl_idx_o == 0, "R7 zero clk", err_o, 1);
  endtask

  task automatic test_hold();
    logic [31:0] f;
    run_case("R8 hold base", 1'b1, 32'd100000000, 32'd400000);
    f = freq_o;
    @(negedge clk_i);
    chk(!done_o, "R8 done one cycle", done_o, 0);
    mod_clk_i = 32'd7; target_i = 32'd1;
    repeat (5) @(negedge clk_i);
    chk(freq_o == f, "R8 result held", freq_o, f);
  endtask

  task automatic test_busy_start();
    pulse_start(1'b0, 32'd50000000, 32'd1000000);
    repeat (40) @(negedge clk_i);
    mode_i = 1'b1; mod_clk_i = 32'd77; target_i = 32'd3; start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    wait_done();
    check_result("R9 ignore start", 1'b0, 32'd50000000, 32'd1000000);
    chk(freq_o <= 32'd1000000, "R10 not above target", freq_o, 1000000);
    @(negedge clk_i);
    chk(!busy_o, "R9 no second search", busy_o, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    test_reset();
    rst_ni = 1'b1;
    @(negedge clk_i);
    test_baud_sweep();
    test_delay_sweep();
    test_known();
    test_error();
    test_zero_clk();
    test_hold();
    test_busy_start();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule